// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, A and B, and moves data between them in either direction. Each direction has a storage register of its own: a rising edge on the A capture strobe stores the value on bus A, and a rising edge on the B capture strobe stores the value on bus B. For each direction a select input chooses what the driven bus carries. It can carry the live value of the opposite bus, or the copy held in that bus's register.

An active-low enable and a direction input decide which bus, if either, is driven. Storage keeps working while both buses are released. The bidirectional pins are split into an input vector, an output vector and an output-enable vector per bus, so that a pad ring can build the tristate buffers outside the block.

All capture strobes are sampled on a single system clock. The data outputs are registered, so changing a select moves an output from one value to another in a single step.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers, the strobe history and both output data vectors, so a_out and b_out read 0 after reset.
- R2: The output enables follow en_n and dir in the same cycle. With en_n=0 and dir=0, a_oe is all ones and b_oe is all zeros. With en_n=0 and dir=1, b_oe is all ones and a_oe is all zeros. With en_n=1, both are all zeros.
- R3: If cap_a is sampled low on one clock and high on the next, the A register loads the bus-A value at that second clock. With sel_ab=1, that value is on b_out one clock later.
- R4: If cap_b is sampled low on one clock and high on the next, the B register loads the bus-B value at that second clock. With sel_ba=1, that value is on a_out one clock later.
- R5: A strobe held steady, whether high or low, leaves its register unchanged whatever its bus carries.
- R6: With sel_ab=0, b_out equals the bus-A value sampled at the previous clock. With sel_ba=0, a_out equals the bus-B value sampled at the previous clock.
- R7: With sel_ab=1, b_out shows the A register. With sel_ba=1, a_out shows the B register.
- R8: Capture works for every value of en_n and dir, including en_n=1 when neither bus is driven.
- R9: The bus value used for capture and for live transfer is the block's own output when that bus's enable is asserted. Otherwise it is the external input.
- R10: A change of select takes the output from the old source straight to the new one at the next clock, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0: drive bus A, 1: drive bus B |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | WIDTH | Value arriving from bus A pins |
| a_out | output | WIDTH | Value to drive onto bus A |
| a_oe | output | WIDTH | Per-bit output enable for bus A |
| b_in | input | WIDTH | Value arriving from bus B pins |
| b_out | output | WIDTH | Value to drive onto bus B |
| b_oe | output | WIDTH | Per-bit output enable for bus B |

## Verification
The output enables are combinational, so they are checked in the same cycle their controls change. A live transfer shows on the far bus one clock after the input is sampled. A stored value needs two clocks after the strobe's rising sample: one to load the register and one to pass through the output register.

The bench drives inputs just after the falling edge and pushes the expected outputs for the coming rising edge into a queue. A monitor pops each item at the next falling edge, so every comparison lands exactly one register stage after the stimulus that caused it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_BUSA = 2'd1,
      DRV_BUSB = 2'd2
   } drive_e;

   // decode of the active-low enable and the direction control
   function automatic drive_e decode_drive(input logic en_n, input logic dir);
      if (en_n)     return DRV_NONE;
      else if (dir) return DRV_BUSB;
      else          return DRV_BUSA;
   endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det #(
   parameter int CHANNELS = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CHANNELS-1:0] strobe,
   output logic [CHANNELS-1:0] rise
);
   if (CHANNELS < 1) begin : g_bad
      $error("xcvr_edge_det: CHANNELS must be at least 1");
   end

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      logic hist_q;
      always_ff @(posedge clk) begin
         if (rst) hist_q <= 1'b0;
         else     hist_q <= strobe[ch];
      end
      assign rise[ch] = strobe[ch] & ~hist_q;
   end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad
      $error("xcvr_store: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             use_stored,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad
      $error("xcvr_out_path: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pick;

   always_comb begin
      pick = use_stored ? stored : live;
   end

   // a single register stage, so a select change switches in one step
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= pick;
   end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_n,
   input  logic             dir,
   input  logic             cap_a,
   input  logic             cap_b,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);
   localparam int STROBES = 2;
   localparam int IDX_A   = 0;
   localparam int IDX_B   = 1;

   if (WIDTH < 1) begin : g_bad
      $error("bus_xcvr_reg: WIDTH must be at least 1");
   end

   drive_e           drive;
   logic             drv_a;
   logic             drv_b;
   logic [WIDTH-1:0] a_seen;
   logic [WIDTH-1:0] b_seen;
   logic [WIDTH-1:0] store_a;
   logic [WIDTH-1:0] store_b;
   logic [STROBES-1:0] rise;

   always_comb begin
      drive = decode_drive(en_n, dir);
      drv_a = (drive == DRV_BUSA);
      drv_b = (drive == DRV_BUSB);
   end

   assign a_oe = {WIDTH{drv_a}};
   assign b_oe = {WIDTH{drv_b}};

   // a driven bus reads back the block's own output
   assign a_seen = drv_a ? a_out : a_in;
   assign b_seen = drv_b ? b_out : b_in;

   xcvr_edge_det #(.CHANNELS(STROBES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .strobe ({cap_b, cap_a}),
      .rise   (rise)
   );

   xcvr_store #(.WIDTH(WIDTH)) u_store_a (
      .clk  (clk),
      .rst  (rst),
      .load (rise[IDX_A]),
      .d    (a_seen),
      .q    (store_a)
   );

   xcvr_store #(.WIDTH(WIDTH)) u_store_b (
      .clk  (clk),
      .rst  (rst),
      .load (rise[IDX_B]),
      .d    (b_seen),
      .q    (store_b)
   );

   xcvr_out_path #(.WIDTH(WIDTH)) u_path_to_b (
      .clk        (clk),
      .rst        (rst),
      .use_stored (sel_ab),
      .live       (a_seen),
      .stored     (store_a),
      .q          (b_out)
   );

   xcvr_out_path #(.WIDTH(WIDTH)) u_path_to_a (
      .clk        (clk),
      .rst        (rst),
      .use_stored (sel_ba),
      .live       (b_seen),
      .stored     (store_b),
      .q          (a_out)
   );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             en_n,
   input logic             dir,
   input logic             cap_a,
   input logic             cap_b,
   input logic             sel_ab,
   input logic             sel_ba,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_oe
);
   logic             ca_hist;
   logic             cb_hist;
   logic             ca_rise;
   logic             cb_rise;
   logic [WIDTH-1:0] a_bus;
   logic [WIDTH-1:0] b_bus;

   always_ff @(posedge clk) begin
      if (rst) begin
         ca_hist <= 1'b0;
         cb_hist <= 1'b0;
      end else begin
         ca_hist <= cap_a;
         cb_hist <= cap_b;
      end
   end

   assign ca_rise = cap_a && !ca_hist;
   assign cb_rise = cap_b && !cb_hist;
   assign a_bus   = (a_oe != '0) ? a_out : a_in;
   assign b_bus   = (b_oe != '0) ? b_out : b_in;

   AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !((a_oe != '0) && (b_oe != '0)));                                  // R2
   AST_OE_RELEASED: assert property (@(posedge clk) disable iff (rst)
      en_n |-> (a_oe == '0) && (b_oe == '0));                            // R2
   AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (rst)
      !sel_ab |=> b_out == $past(a_bus));                                // R6
   AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (rst)
      !sel_ba |=> a_out == $past(b_bus));                                // R6
   AST_CAPTURE_A: assert property (@(posedge clk) disable iff (rst)
      (sel_ab && ca_rise) ##1 sel_ab |=> b_out == $past(a_bus, 2));      // R3
   AST_CAPTURE_B: assert property (@(posedge clk) disable iff (rst)
      (sel_ba && cb_rise) ##1 sel_ba |=> a_out == $past(b_bus, 2));      // R4
   AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
      (sel_ab && !ca_rise) ##1 sel_ab |=> $stable(b_out));               // R5
   AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
      (sel_ba && !cb_rise) ##1 sel_ba |=> $stable(a_out));               // R5
endmodule

bind bus_xcvr_reg xcvr_checker #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .en_n   (en_n),
   .dir    (dir),
   .cap_a  (cap_a),
   .cap_b  (cap_b),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_oe   (b_oe)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] exp_a;
      logic [W-1:0] exp_b;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en_n = 1'b1, dir = 1'b0;
   logic         cap_a = 1'b0, cap_b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;
   item_t sb[$];

   // reference model state
   logic [W-1:0] m_sa = '0, m_sb = '0, m_aout = '0, m_bout = '0;
   logic         m_caq = 1'b0, m_cbq = 1'b0;

   always #5 clk = ~clk;

   bus_xcvr_reg #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .en_n(en_n), .dir(dir),
      .cap_a(cap_a), .cap_b(cap_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: apply inputs for one cycle, push the outputs due after the next edge
   task automatic step(input logic en, input logic d, input logic ca, input logic cb,
                       input logic sab, input logic sba,
                       input logic [W-1:0] ain, input logic [W-1:0] bin, input string tag);
      logic         oa, ob;
      logic [W-1:0] sa, sbv;
      item_t        it;
      @(negedge clk);
      #1;
      en_n = en; dir = d; cap_a = ca; cap_b = cb;
      sel_ab = sab; sel_ba = sba; a_in = ain; b_in = bin;
      oa = !en && !d;
      ob = !en && d;
      #1;
      check("R2", "a_oe", a_oe, {W{oa}});
      check("R2", "b_oe", b_oe, {W{ob}});
      sa  = oa ? m_aout : ain;
      sbv = ob ? m_bout : bin;
      it.exp_a = sba ? m_sb : sbv;
      it.exp_b = sab ? m_sa : sa;
      it.tag   = tag;
      if (ca && !m_caq) m_sa = sa;
      if (cb && !m_cbq) m_sb = sbv;
      m_caq  = ca;
      m_cbq  = cb;
      m_aout = it.exp_a;
      m_bout = it.exp_b;
      sb.push_back(it);
   endtask

   // monitor: compare one item per cycle, away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, "a_out", a_out, it.exp_a);
            check(it.tag, "b_out", b_out, it.exp_b);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!ended) begin
         ended = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      #1;
      check("R1", "a_out after reset", a_out, '0);
      check("R1", "b_out after reset", b_out, '0);
      check("R2", "a_oe released", a_oe, '0);

      // R2 all enable/direction combinations, R6 live both ways
      step(0, 1, 0, 0, 0, 0, 8'h11, 8'h22, "R6");
      step(0, 1, 0, 0, 0, 0, 8'hA5, 8'h3C, "R6");
      step(0, 0, 0, 0, 0, 0, 8'h77, 8'h5E, "R6");
      step(0, 0, 0, 0, 0, 0, 8'h01, 8'hC3, "R6");
      step(1, 0, 0, 0, 0, 0, 8'h10, 8'h20, "R2");
      step(1, 1, 0, 0, 0, 0, 8'h30, 8'h40, "R2");

      // R3 capture A, R7 show stored A on bus B
      step(0, 1, 0, 0, 0, 0, 8'h5A, 8'h00, "R3");
      step(0, 1, 1, 0, 0, 0, 8'h5A, 8'h00, "R3");
      step(0, 1, 1, 0, 1, 0, 8'h99, 8'h00, "R7");
      // R5 strobe held high, bus changes
      step(0, 1, 1, 0, 1, 0, 8'hEE, 8'h00, "R5");
      step(0, 1, 0, 0, 1, 0, 8'h66, 8'h00, "R5");
      // R10 select toggling each cycle
      step(0, 1, 0, 0, 0, 0, 8'h81, 8'h00, "R10");
      step(0, 1, 0, 0, 1, 0, 8'h82, 8'h00, "R10");
      step(0, 1, 0, 0, 0, 0, 8'h83, 8'h00, "R10");
      step(0, 1, 0, 0, 1, 0, 8'h84, 8'h00, "R10");

      // R8 capture B while both buses are released, R4 show it on A
      step(1, 0, 0, 0, 0, 0, 8'h00, 8'hC7, "R8");
      step(1, 0, 0, 1, 0, 0, 8'h00, 8'hC7, "R8");
      step(0, 0, 0, 1, 0, 1, 8'h00, 8'h12, "R4");
      step(0, 0, 0, 0, 0, 1, 8'h00, 8'h34, "R4");
      step(0, 0, 0, 0, 0, 1, 8'h00, 8'h56, "R5");

      // R9 capture of the driven bus: A driven live from B
      step(0, 0, 0, 0, 0, 0, 8'hFF, 8'h33, "R9");
      step(0, 0, 0, 0, 0, 0, 8'hFF, 8'h33, "R9");
      step(0, 0, 1, 0, 0, 0, 8'hFF, 8'h33, "R9");
      step(0, 1, 0, 0, 1, 0, 8'hFF, 8'h00, "R9");
      step(0, 1, 0, 0, 1, 0, 8'h0F, 8'h00, "R9");

      // R1 reset mid-run clears stores
      @(negedge clk);
      #1 rst = 1'b1;
      @(negedge clk);
      #1 rst = 1'b0;
      m_sa = '0; m_sb = '0; m_aout = '0; m_bout = '0; m_caq = 0; m_cbq = 0;
      step(0, 1, 0, 0, 1, 1, 8'h44, 8'h55, "R1");
      step(0, 1, 0, 0, 1, 1, 8'h44, 8'h55, "R1");

      repeat (3) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule